// File: doc/BRIEF.md
# Capture Timer with Interrupt Controller

This block is a 16-bit free-running counter with two capture registers and a small interrupt collector. It sits on an 8-bit CPU I/O bus and uses single-cycle read and write strobes. Software reads the counter coherently: a read of the low byte of the command capture copies all 16 bits into a latch, so the later high-byte read returns a matching half. A hardware edge on the capture input freezes the counter value in a second register and raises the capture interrupt.

Five sources share one status register. Bit 0 is the sub-controller, bit 1 is the serial port, bit 2 is input capture, bit 3 is counter overflow and bit 4 is an external source. A write-only enable register sits at the same address as the status register. The request output is high while any enabled status bit is set. Each kind of flag has its own clear path. Reading the high byte of the edge capture clears the capture flag. Command-register bits clear the overflow flag and the three pulse-driven flags.

Edge detection is a two-state machine. In CAP_LOW it waits for the capture input to be high. The "rise" transition CAP_LOW→CAP_HIGH stores the counter and sets the capture flag. In CAP_HIGH it waits for the input to go low. The "fall" transition CAP_HIGH→CAP_LOW re-arms the detector.

Top module: `capt_irq_timer`

## Requirements
- R1: After reset the counter, both captures, status and enable are zero and `irq` is low.
- R2: The counter advances by one on each clock edge where `tick_en` is high and holds otherwise.
- R3: A counting edge with the counter at 0xFFFF wraps it to 0x0000 and sets status bit 3.
- R4: Read data appears on `bus_rdata` one cycle after the read strobe. A read at address 0 copies the whole counter into the latch and returns its low byte. A read at address 1 returns latch bits 15:8 without re-latching.
- R5: When the state machine is in CAP_LOW and `cap_in` is high, the counter is copied into the edge capture register and status bit 2 is set. An input held high captures only once.
- R6: A read at address 2 returns the edge capture low byte and leaves status bit 2 alone. A read at address 3 returns the edge capture high byte and clears status bit 2.
- R7: A write at address 0 is a command. Data bit 2 clears status bit 3. Data bits 0, 1 and 4 clear status bits 0, 1 and 4. Data bits 3, 5, 6 and 7 have no effect.
- R8: The one-cycle pulses `src_pulse[0]`, `src_pulse[1]` and `src_pulse[2]` set status bits 0, 1 and 4.
- R9: A read at address 4 returns the status in bits 4:0 with zeros above. A write at address 4 loads the enable register from data bits 4:0 and leaves the status unchanged.
- R10: `irq` is the OR over bits 4:0 of status AND enable. It follows an enable write on the cycle after the write strobe.
- R11: When a set and a clear reach the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counter advance enable, one cycle per count |
| cap_in | input | 1 | Capture trigger, synchronous to clk |
| src_pulse | input | 3 | Pulses from sub-controller, serial port, external source |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| irq | output | 1 | Interrupt request, active high |

## Verification
The properties assume that `cap_in` and the source pulses are already synchronous to `clk`. They also assume that read and write strobes are never high together. The clear properties apply only when no set can occur in the same cycle, because R11 gives priority to the set. The bench changes every input on the falling edge. It never asserts both strobes together. It keeps `tick_en` low during register reads so that the expected captured values are fixed. It produces a same-cycle set and clear only in the test written for that case.

// File: rtl/ct_pkg.sv
package ct_pkg;
    localparam int CNT_W = 16;
    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int NSRC  = 5;
    localparam int NPULSE = 3;

    localparam logic [AW-1:0] A_CAPC_LO = 3'd0;
    localparam logic [AW-1:0] A_CAPC_HI = 3'd1;
    localparam logic [AW-1:0] A_CAPE_LO = 3'd2;
    localparam logic [AW-1:0] A_CAPE_HI = 3'd3;
    localparam logic [AW-1:0] A_IRQ     = 3'd4;

    localparam int B_SUB = 0;
    localparam int B_SER = 1;
    localparam int B_ICF = 2;
    localparam int B_OVF = 3;
    localparam int B_EXT = 4;

    localparam int CMD_OVF_CLR = 2;

    typedef enum logic {
        CAP_LOW  = 1'b0,
        CAP_HIGH = 1'b1
    } cap_state_t;
endpackage

// File: rtl/ct_counter.sv
module ct_counter #(
    parameter int CNT_W = ct_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             latch_req,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] latch,
    output logic             wrap_hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] latch_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (latch_req) begin
            latch_q <= cnt_q;
        end
    end

    assign wrap_hit = tick_en && (cnt_q == CNT_MAX);
    assign cnt      = cnt_q;
    assign latch    = latch_q;
endmodule

// File: rtl/ct_edge_cap.sv
module ct_edge_cap #(
    parameter int CNT_W = ct_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_in,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] ecap,
    output logic             cap_hit
);
    import ct_pkg::*;

    cap_state_t       state_q, state_d;
    logic [CNT_W-1:0] ecap_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAP_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        cap_hit = 1'b0;
        unique case (state_q)
            CAP_LOW: begin
                if (cap_in) begin
                    state_d = CAP_HIGH;   // rise
                    cap_hit = 1'b1;
                end
            end
            CAP_HIGH: begin
                if (!cap_in) begin
                    state_d = CAP_LOW;    // fall
                end
            end
            default: state_d = CAP_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecap_q <= '0;
        end else if (cap_hit) begin
            ecap_q <= cnt;
        end
    end

    assign ecap = ecap_q;
endmodule

// File: rtl/ct_irq_ctrl.sv
module ct_irq_ctrl #(
    parameter int NSRC = ct_pkg::NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_vec,
    input  logic [NSRC-1:0] clr_vec,
    input  logic            en_wr,
    input  logic [NSRC-1:0] en_data,
    output logic [NSRC-1:0] status,
    output logic [NSRC-1:0] enable,
    output logic            irq
);
    logic [NSRC-1:0] status_q;
    logic [NSRC-1:0] enable_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status_q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                status_q[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                status_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (en_wr) begin
            enable_q <= en_data;
        end
    end

    assign status = status_q;
    assign enable = enable_q;
    assign irq    = |(status_q & enable_q);
endmodule

// File: rtl/capt_irq_timer.sv
module capt_irq_timer #(
    parameter int CNT_W  = ct_pkg::CNT_W,
    parameter int DW     = ct_pkg::DW,
    parameter int AW     = ct_pkg::AW,
    parameter int NSRC   = ct_pkg::NSRC,
    parameter int NPULSE = ct_pkg::NPULSE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              cap_in,
    input  logic [NPULSE-1:0] src_pulse,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq
);
    import ct_pkg::*;

    localparam int HI_LSB = CNT_W - DW;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] latch_q;
    logic [CNT_W-1:0] ecap_q;
    logic [NSRC-1:0]  status_q;
    logic [NSRC-1:0]  enable_q;
    logic [NSRC-1:0]  set_vec;
    logic [NSRC-1:0]  clr_vec;
    logic             wrap_hit;
    logic             cap_hit;
    logic             rd_capc_lo;
    logic             rd_cape_hi;
    logic             wr_cmd;
    logic             wr_en;
    logic [DW-1:0]    rdata_q;
    logic             unused_wdata;

    assign rd_capc_lo = bus_rd && (bus_addr == A_CAPC_LO);
    assign rd_cape_hi = bus_rd && (bus_addr == A_CAPE_HI);
    assign wr_cmd     = bus_wr && (bus_addr == A_CAPC_LO);
    assign wr_en      = bus_wr && (bus_addr == A_IRQ);
    assign unused_wdata = ^bus_wdata[DW-1:NSRC];

    ct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .latch_req (rd_capc_lo),
        .cnt       (cnt_q),
        .latch     (latch_q),
        .wrap_hit  (wrap_hit)
    );

    ct_edge_cap #(.CNT_W(CNT_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_in  (cap_in),
        .cnt     (cnt_q),
        .ecap    (ecap_q),
        .cap_hit (cap_hit)
    );

    always_comb begin
        set_vec        = '0;
        set_vec[B_SUB] = src_pulse[0];
        set_vec[B_SER] = src_pulse[1];
        set_vec[B_ICF] = cap_hit;
        set_vec[B_OVF] = wrap_hit;
        set_vec[B_EXT] = src_pulse[2];

        clr_vec        = '0;
        clr_vec[B_SUB] = wr_cmd && bus_wdata[B_SUB];
        clr_vec[B_SER] = wr_cmd && bus_wdata[B_SER];
        clr_vec[B_ICF] = rd_cape_hi;
        clr_vec[B_OVF] = wr_cmd && bus_wdata[CMD_OVF_CLR];
        clr_vec[B_EXT] = wr_cmd && bus_wdata[B_EXT];
    end

    ct_irq_ctrl #(.NSRC(NSRC)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .en_wr   (wr_en),
        .en_data (bus_wdata[NSRC-1:0]),
        .status  (status_q),
        .enable  (enable_q),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                A_CAPC_LO: rdata_q <= cnt_q[DW-1:0];
                A_CAPC_HI: rdata_q <= latch_q[CNT_W-1:HI_LSB];
                A_CAPE_LO: rdata_q <= ecap_q[DW-1:0];
                A_CAPE_HI: rdata_q <= ecap_q[CNT_W-1:HI_LSB];
                A_IRQ:     rdata_q <= DW'(status_q);
                default:   rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
    parameter int CNT_W = ct_pkg::CNT_W,
    parameter int DW    = ct_pkg::DW,
    parameter int AW    = ct_pkg::AW,
    parameter int NSRC  = ct_pkg::NSRC
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             cap_in,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [DW-1:0]    bus_wdata,
    input logic [CNT_W-1:0] cnt,
    input logic [NSRC-1:0]  status,
    input logic [NSRC-1:0]  enable,
    input logic             irq
);
    import ct_pkg::*;

    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> cnt == $past(cnt));

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> cnt == $past(cnt) + CNT_W'(1));

    p_wrap_sets_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cnt == '1) |=> (status[B_OVF] && cnt == '0));

    p_rise_sets_icf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_in && !$past(cap_in)) |=> status[B_ICF]);

    p_hi_read_clears_icf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_CAPE_HI && !cap_in) |=> !status[B_ICF]);

    p_cmd_clears_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CAPC_LO && bus_wdata[CMD_OVF_CLR]
         && !(tick_en && cnt == '1)) |=> !status[B_OVF]);

    p_no_enable_no_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq);

    p_no_status_no_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !irq);
endmodule

bind capt_irq_timer ct_checker #(
    .CNT_W(CNT_W), .DW(DW), .AW(AW), .NSRC(NSRC)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .cap_in    (cap_in),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .cnt       (cnt_q),
    .status    (status_q),
    .enable    (enable_q),
    .irq       (irq)
);

// File: tb/capt_irq_timer_tb_top.sv
`timescale 1ns/1ps
module capt_irq_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       cap_in = 1'b0;
    logic [2:0] src_pulse = '0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    logic [15:0] model_cnt;

    always #2 clk = ~clk;

    capt_irq_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cap_in(cap_in),
        .src_pulse(src_pulse), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    // Expected counter from R2
    always @(posedge clk) begin
        if (!rst_n) model_cnt <= '0;
        else if (tick_en) model_cnt <= model_cnt + 16'd1;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] m);
        @(negedge clk); src_pulse = m;
        @(negedge clk); src_pulse = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 irq", {15'd0, irq}, 16'd0);
        bus_read(3'd4, d); chk("R1 status", {8'd0, d}, 16'd0);
        bus_read(3'd2, d); chk("R1 edge capture", {8'd0, d}, 16'd0);
    endtask

    task automatic t_latch();
        logic [7:0] d;
        ticks(300);
        bus_read(3'd0, d); chk("R4 low byte latches", {8'd0, d}, 16'h002C);
        ticks(300);
        bus_read(3'd1, d); chk("R4 high byte no relatch", {8'd0, d}, 16'h0001);
        bus_read(3'd0, d); chk("R2 counter value", {8'd0, d}, {8'd0, model_cnt[7:0]});
    endtask

    task automatic t_capture();
        logic [7:0] d;
        logic [15:0] exp;
        exp = model_cnt;
        @(negedge clk); cap_in = 1'b1;
        repeat (2) @(negedge clk);
        ticks(5);
        @(negedge clk); cap_in = 1'b0;
        bus_read(3'd4, d); chk("R5 capture flag", {15'd0, d[2]}, 16'd1);
        bus_read(3'd2, d); chk("R5 held input captures once", {8'd0, d}, {8'd0, exp[7:0]});
        bus_read(3'd4, d); chk("R6 low read keeps flag", {15'd0, d[2]}, 16'd1);
        bus_read(3'd3, d); chk("R6 high byte", {8'd0, d}, {8'd0, exp[15:8]});
        bus_read(3'd4, d); chk("R6 high read clears flag", {15'd0, d[2]}, 16'd0);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        @(negedge clk); cap_in = 1'b1;
        @(negedge clk); cap_in = 1'b0;
        chk("R10 irq without enable", {15'd0, irq}, 16'd0);
        bus_write(3'd4, 8'h04);
        chk("R10 irq after enable", {15'd0, irq}, 16'd1);
        bus_read(3'd4, d); chk("R9 enable write leaves status", {8'd0, d}, 16'h0004);
        bus_write(3'd4, 8'h1B);
        chk("R10 irq masked", {15'd0, irq}, 16'd0);
        bus_read(3'd3, d);
        bus_write(3'd4, 8'h00);
    endtask

    task automatic t_sources();
        logic [7:0] d;
        pulse(3'b001); pulse(3'b010); pulse(3'b100);
        bus_read(3'd4, d); chk("R8 pulse sources", {8'd0, d}, 16'h0013);
        bus_write(3'd0, 8'h01);
        bus_read(3'd4, d); chk("R7 clear bit0", {8'd0, d}, 16'h0012);
        bus_write(3'd0, 8'hE8);
        bus_read(3'd4, d); chk("R7 other bits ignored", {8'd0, d}, 16'h0012);
        bus_write(3'd0, 8'h12);
        bus_read(3'd4, d); chk("R7 clear bits 1 and 4", {8'd0, d}, 16'h0000);
    endtask

    task automatic t_overflow();
        logic [7:0] d;
        int n;
        n = 65536 - int'(model_cnt) - 1;
        ticks(n);
        bus_read(3'd4, d); chk("R3 no overflow before wrap", {15'd0, d[3]}, 16'd0);
        ticks(1);
        bus_read(3'd4, d); chk("R3 overflow flag", {15'd0, d[3]}, 16'd1);
        bus_read(3'd0, d); chk("R3 wrapped to zero", {8'd0, d}, 16'h0000);
        bus_read(3'd1, d); chk("R3 wrapped high byte", {8'd0, d}, 16'h0000);
        bus_write(3'd0, 8'h04);
        bus_read(3'd4, d); chk("R7 overflow clear", {15'd0, d[3]}, 16'd0);
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        @(negedge clk); cap_in = 1'b1; bus_addr = 3'd3; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; cap_in = 1'b0;
        bus_read(3'd4, d); chk("R11 capture beats read clear", {15'd0, d[2]}, 16'd1);
        @(negedge clk); src_pulse = 3'b001; bus_addr = 3'd0; bus_wdata = 8'h01; bus_wr = 1'b1;
        @(negedge clk); src_pulse = '0; bus_wr = 1'b0;
        bus_read(3'd4, d); chk("R11 pulse beats command clear", {15'd0, d[0]}, 16'd1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_latch();
                t_capture();
                t_irq();
                t_sources();
                t_overflow();
                t_set_wins();
            end
            begin
                repeat (150000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule